// File: doc/BRIEF.md
# Cache Inquire Snoop Responder

This block answers snoop (inquire) cycles that an outside bus agent runs against an on-chip cache. The agent pulses a strobe together with a line address (physical address bits 31 down to 5), an even-parity bit for that address and an invalidate request. The block captures all of them on the strobe edge and checks the parity. In the following clock it presents the address to the cache tag array and takes back a hit flag and a modified flag.

Two clocks after the strobe is sampled, the block drives its registered answers: a hit output that keeps its value until the next snoop completes, a one-clock parity-error pulse and a hit-to-modified output. For a clean hit it also sends the tag array one line-state update, either shared or invalid. For a hit on a modified line it first raises a writeback request and keeps the hit-to-modified output high until the writeback is reported done. Only then does it send the line's final state. A new snoop can be strobed in every clock.

Top module: `snp_responder`

## Requirements
- R1: While reset is active and after it is released, snp_hit, snp_hitm, snp_perr, wb_req, tag_req and upd_valid are all 0.
- R2: One clock after a strobe is sampled, tag_req is 1 and tag_addr equals the captured snp_addr.
- R3: Two clocks after a strobe is sampled, snp_hit is 1 if the tag lookup reported a hit and 0 if it reported a miss.
- R4: snp_hit changes only when a snoop result arrives and holds its value during idle clocks.
- R5: When snp_addr together with snp_par has an odd number of ones, snp_perr is 1 for exactly one clock, two clocks after the strobe. The lookup and its results still happen normally.
- R6: A clean hit (hit without modified) produces, in the same clock as snp_hit, one upd_valid pulse for that address. upd_state is 2'b01 (shared) if snp_inval was 0 and 2'b00 (invalid) if it was 1. A miss produces no update.
- R7: A hit on a modified line raises snp_hitm and wb_req two clocks after the strobe, with wb_addr set to the snoop address, and produces no immediate update. Both stay high until wb_done is sampled and are 0 in the clock after that.
- R8: After wb_done, the block sends one update for wb_addr: 2'b00 (invalid) if the snoop carried invalidate, else 2'b01 (shared). It comes one clock after snp_hitm falls, unless that clock is taken by R10.
- R9: Strobes in consecutive clocks are each answered in their own clock, two clocks after their own strobe.
- R10: When a clean-hit update and a pending post-writeback update fall in the same clock, the clean-hit update is sent first. The post-writeback update follows in the next clock that has no clean-hit update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| snp_strobe | input | 1 | Snoop address strobe, active high |
| snp_addr | input | 27 | Snoop line address (address bits 31:5) |
| snp_par | input | 1 | Even parity bit over snp_addr |
| snp_inval | input | 1 | 1: a hit line ends invalid; 0: ends shared |
| tag_req | output | 1 | Tag lookup request |
| tag_addr | output | 27 | Tag lookup address |
| tag_hit | input | 1 | Tag response: line valid in either cache |
| tag_mod | input | 1 | Tag response: line modified in data cache |
| snp_hit | output | 1 | Snoop hit, held between snoops |
| snp_hitm | output | 1 | Snoop hit a modified line, held until writeback done |
| snp_perr | output | 1 | One-clock address parity error pulse |
| upd_valid | output | 1 | Line-state update strobe |
| upd_addr | output | 27 | Line address of the update |
| upd_state | output | 2 | New line state: 2'b01 shared, 2'b00 invalid |
| wb_req | output | 1 | Writeback request for a modified line |
| wb_addr | output | 27 | Line address to write back |
| wb_done | input | 1 | Writeback completed pulse |

## Verification
The update port can be claimed in one clock by two sources: a clean hit leaving the pipeline and the final-state update owed after a writeback finishes. The bench provokes this by strobing a clean hit one clock before it pulses wb_done, so both updates are ready at the same edge. It then requires the clean-hit address and state in the first clock and the post-writeback address and shared state in the next. A parity error on a hit in a back-to-back stream is checked the same way: the error pulse and the normal hit answer must both appear in that snoop's own clock.

// File: rtl/snp_pkg.sv
package snp_pkg;
   typedef enum logic [1:0] {
      LS_INVALID = 2'b00,
      LS_SHARED  = 2'b01
   } line_st_e;

   function automatic line_st_e final_state(input logic inval);
      return inval ? LS_INVALID : LS_SHARED;
   endfunction
endpackage

// File: rtl/snp_parity.sv
module snp_parity #(
   parameter int W     = 27,
   parameter int GRP_W = 8
) (
   input  logic [W-1:0] data,
   input  logic         par,
   output logic         err
);
   localparam int NG  = (W + GRP_W - 1) / GRP_W;
   localparam int PAD = NG * GRP_W - W;

   logic [NG*GRP_W-1:0] padded;
   logic [NG-1:0]       grp;

   generate
      if (PAD > 0) begin : g_pad
         assign padded = {{PAD{1'b0}}, data};
      end else begin : g_nopad
         assign padded = data;
      end
      for (genvar g = 0; g < NG; g++) begin : g_grp
         assign grp[g] = ^padded[g*GRP_W +: GRP_W];
      end
   endgenerate

   // even parity: total ones including par must be even
   assign err = (^grp) ^ par;
endmodule

// File: rtl/snp_pipe.sv
module snp_pipe #(
   parameter int W = 27
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         strobe,
   input  logic [W-1:0] addr,
   input  logic         inval,
   input  logic         perr_in,
   input  logic         tag_hit,
   input  logic         tag_mod,
   output logic         lk_valid,
   output logic [W-1:0] lk_addr,
   output logic         res_valid,
   output logic [W-1:0] res_addr,
   output logic         res_inval,
   output logic         res_perr,
   output logic         res_hit,
   output logic         res_mod
);
   logic lk_inval, lk_perr;

   // stage 1: capture in the strobe clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_valid <= 1'b0;
         lk_addr  <= '0;
         lk_inval <= 1'b0;
         lk_perr  <= 1'b0;
      end else begin
         lk_valid <= strobe;
         if (strobe) begin
            lk_addr  <= addr;
            lk_inval <= inval;
            lk_perr  <= perr_in;
         end
      end
   end

   // stage 2: capture tag response
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_addr  <= '0;
         res_inval <= 1'b0;
         res_perr  <= 1'b0;
         res_hit   <= 1'b0;
         res_mod   <= 1'b0;
      end else begin
         res_valid <= lk_valid;
         if (lk_valid) begin
            res_addr  <= lk_addr;
            res_inval <= lk_inval;
            res_perr  <= lk_perr;
            res_hit   <= tag_hit;
            res_mod   <= tag_hit & tag_mod;
         end
      end
   end
endmodule

// File: rtl/snp_wb_track.sv
module snp_wb_track #(
   parameter int W = 27
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] start_addr,
   input  logic         start_inval,
   input  logic         wb_done,
   input  logic         fin_take,
   output logic         pend,
   output logic [W-1:0] wb_addr,
   output logic         fin_req,
   output logic         fin_inval
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         wb_addr   <= '0;
         fin_req   <= 1'b0;
         fin_inval <= 1'b0;
      end else begin
         if (start) begin
            pend      <= 1'b1;
            wb_addr   <= start_addr;
            fin_inval <= start_inval;
         end else if (pend && wb_done) begin
            pend <= 1'b0;
         end

         if (pend && wb_done)
            fin_req <= 1'b1;
         else if (fin_take)
            fin_req <= 1'b0;
      end
   end
endmodule

// File: rtl/snp_responder.sv
module snp_responder #(
   parameter int ADDR_W = 27,
   parameter int PAR_GRP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_strobe,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic              snp_par,
   input  logic              snp_inval,
   output logic              tag_req,
   output logic [ADDR_W-1:0] tag_addr,
   input  logic              tag_hit,
   input  logic              tag_mod,
   output logic              snp_hit,
   output logic              snp_hitm,
   output logic              snp_perr,
   output logic              upd_valid,
   output logic [ADDR_W-1:0] upd_addr,
   output logic [1:0]        upd_state,
   output logic              wb_req,
   output logic [ADDR_W-1:0] wb_addr,
   input  logic              wb_done
);
   import snp_pkg::*;

   generate
      if (ADDR_W < 2) begin : g_bad_w
         $error("snp_responder: ADDR_W must be at least 2");
      end
      if (PAR_GRP_W < 1) begin : g_bad_g
         $error("snp_responder: PAR_GRP_W must be at least 1");
      end
   endgenerate

   logic              perr_now;
   logic              res_valid, res_inval, res_perr, res_hit, res_mod;
   logic [ADDR_W-1:0] res_addr;
   logic              pend, fin_req, fin_inval, fin_take, clean_upd;

   snp_parity #(.W(ADDR_W), .GRP_W(PAR_GRP_W)) u_par (
      .data (snp_addr),
      .par  (snp_par),
      .err  (perr_now)
   );

   snp_pipe #(.W(ADDR_W)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (snp_strobe),
      .addr      (snp_addr),
      .inval     (snp_inval),
      .perr_in   (perr_now),
      .tag_hit   (tag_hit),
      .tag_mod   (tag_mod),
      .lk_valid  (tag_req),
      .lk_addr   (tag_addr),
      .res_valid (res_valid),
      .res_addr  (res_addr),
      .res_inval (res_inval),
      .res_perr  (res_perr),
      .res_hit   (res_hit),
      .res_mod   (res_mod)
   );

   assign clean_upd = res_valid & res_hit & ~res_mod;
   assign fin_take  = fin_req & ~clean_upd;

   snp_wb_track #(.W(ADDR_W)) u_wb (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (res_valid & res_mod),
      .start_addr  (res_addr),
      .start_inval (res_inval),
      .wb_done     (wb_done),
      .fin_take    (fin_take),
      .pend        (pend),
      .wb_addr     (wb_addr),
      .fin_req     (fin_req),
      .fin_inval   (fin_inval)
   );

   assign snp_hitm = pend;
   assign wb_req   = pend;

   // output stage: two clocks after the strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snp_hit   <= 1'b0;
         snp_perr  <= 1'b0;
         upd_valid <= 1'b0;
         upd_addr  <= '0;
         upd_state <= LS_INVALID;
      end else begin
         if (res_valid)
            snp_hit <= res_hit;
         snp_perr <= res_valid & res_perr;
         if (clean_upd) begin
            upd_valid <= 1'b1;
            upd_addr  <= res_addr;
            upd_state <= final_state(res_inval);
         end else if (fin_req) begin
            upd_valid <= 1'b1;
            upd_addr  <= wb_addr;
            upd_state <= final_state(fin_inval);
         end else begin
            upd_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/snp_responder_chk.sv
module snp_responder_chk #(
   parameter int ADDR_W = 27
) (
   input logic              clk,
   input logic              rst_n,
   input logic              snp_strobe,
   input logic [ADDR_W-1:0] snp_addr,
   input logic              tag_req,
   input logic [ADDR_W-1:0] tag_addr,
   input logic              tag_hit,
   input logic              tag_mod,
   input logic              snp_hit,
   input logic              snp_hitm,
   input logic              snp_perr,
   input logic              upd_valid,
   input logic              wb_done
);
   a_r2_lookup_follows: assert property (@(posedge clk) disable iff (!rst_n)
      snp_strobe |=> (tag_req && tag_addr == $past(snp_addr)));

   a_r3_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
      tag_req |=> ##1 (snp_hit == $past(tag_hit, 2)));

   a_r4_hit_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tag_req, 2) |-> $stable(snp_hit));

   a_r5_perr_after_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      snp_perr |-> $past(tag_req, 2));

   a_r6_clean_hit_updates: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tag_req, 2) && $past(tag_hit && !tag_mod, 2)) |-> upd_valid);

   a_r7_hitm_held: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_hitm && !wb_done) |=> snp_hitm);

   a_r7_hitm_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(snp_hitm) |-> snp_hit);

   a_r8_hitm_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_hitm && wb_done) |=> !snp_hitm);
endmodule

bind snp_responder snp_responder_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .snp_strobe (snp_strobe),
   .snp_addr   (snp_addr),
   .tag_req    (tag_req),
   .tag_addr   (tag_addr),
   .tag_hit    (tag_hit),
   .tag_mod    (tag_mod),
   .snp_hit    (snp_hit),
   .snp_hitm   (snp_hitm),
   .snp_perr   (snp_perr),
   .upd_valid  (upd_valid),
   .wb_done    (wb_done)
);

// File: tb/snp_responder_test.sv
module snp_responder_test;
   localparam int AW = 27;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          snp_strobe = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_par = 1'b0;
   logic          snp_inval = 1'b0;
   logic          tag_req;
   logic [AW-1:0] tag_addr;
   logic          tag_hit, tag_mod;
   logic          snp_hit, snp_hitm, snp_perr, upd_valid, wb_req;
   logic [AW-1:0] upd_addr, wb_addr;
   logic [1:0]    upd_state;
   logic          wb_done = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   // bench tag model: bit0 = valid, bit0&bit1 = modified
   assign tag_hit = tag_req & tag_addr[0];
   assign tag_mod = tag_req & tag_addr[0] & tag_addr[1];

   snp_responder uut (
      .clk(clk), .rst_n(rst_n), .snp_strobe(snp_strobe), .snp_addr(snp_addr),
      .snp_par(snp_par), .snp_inval(snp_inval), .tag_req(tag_req),
      .tag_addr(tag_addr), .tag_hit(tag_hit), .tag_mod(tag_mod),
      .snp_hit(snp_hit), .snp_hitm(snp_hitm), .snp_perr(snp_perr),
      .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_state(upd_state),
      .wb_req(wb_req), .wb_addr(wb_addr), .wb_done(wb_done)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic st, input logic [AW-1:0] a,
                        input logic inv, input logic bad_par);
      snp_strobe = st;
      snp_addr   = a;
      snp_inval  = inv;
      snp_par    = (^a) ^ bad_par;
   endtask

   task automatic t_reset;
      chk("R1", "snp_hit", snp_hit, 0);
      chk("R1", "snp_hitm", snp_hitm, 0);
      chk("R1", "snp_perr", snp_perr, 0);
      chk("R1", "wb_req", wb_req, 0);
      chk("R1", "tag_req", tag_req, 0);
      chk("R1", "upd_valid", upd_valid, 0);
   endtask

   task automatic t_single(input logic [AW-1:0] a, input logic inv,
                           input logic bad);
      logic h;
      h = a[0];
      @(negedge clk); drive(1'b1, a, inv, bad);
      @(negedge clk); drive(1'b0, '0, 1'b0, 1'b0);
      chk("R2", "tag_req", tag_req, 1);
      chk("R2", "tag_addr", tag_addr, a);
      @(negedge clk);
      @(negedge clk);
      chk("R3", "snp_hit", snp_hit, h);
      chk("R5", "snp_perr", snp_perr, bad);
      chk("R6", "upd_valid", upd_valid, h);
      if (h) begin
         chk("R6", "upd_addr", upd_addr, a);
         chk("R6", "upd_state", upd_state, inv ? 2'b00 : 2'b01);
      end
      @(negedge clk);
      chk("R5", "snp_perr one clock", snp_perr, 0);
      chk("R6", "upd_valid one clock", upd_valid, 0);
      repeat (3) @(negedge clk);
      chk("R4", "snp_hit held", snp_hit, h);
   endtask

   task automatic t_modified(input logic [AW-1:0] a, input logic inv);
      @(negedge clk); drive(1'b1, a, inv, 1'b0);
      @(negedge clk); drive(1'b0, '0, 1'b0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      chk("R7", "snp_hitm", snp_hitm, 1);
      chk("R7", "wb_req", wb_req, 1);
      chk("R7", "wb_addr", wb_addr, a);
      chk("R7", "no update", upd_valid, 0);
      chk("R3", "snp_hit on modified", snp_hit, 1);
      repeat (3) @(negedge clk);
      chk("R7", "snp_hitm held", snp_hitm, 1);
      wb_done = 1'b1;
      @(negedge clk); wb_done = 1'b0;
      chk("R7", "snp_hitm dropped", snp_hitm, 0);
      chk("R7", "wb_req dropped", wb_req, 0);
      chk("R8", "no update yet", upd_valid, 0);
      @(negedge clk);
      chk("R8", "upd_valid", upd_valid, 1);
      chk("R8", "upd_addr", upd_addr, a);
      chk("R8", "upd_state", upd_state, inv ? 2'b00 : 2'b01);
      @(negedge clk);
      chk("R8", "single update", upd_valid, 0);
   endtask

   task automatic t_back_to_back;
      logic [AW-1:0] a [4];
      logic          iv [4];
      logic          bp [4];
      a[0] = 27'h0123451; iv[0] = 1'b0; bp[0] = 1'b0; // hit -> shared
      a[1] = 27'h0456780; iv[1] = 1'b0; bp[1] = 1'b1; // miss, bad parity
      a[2] = 27'h7ABCDE5; iv[2] = 1'b1; bp[2] = 1'b1; // hit -> invalid, bad parity
      a[3] = 27'h0000100; iv[3] = 1'b1; bp[3] = 1'b0; // miss
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (k >= 3 && k - 3 < 4) begin
            chk("R9", "snp_hit", snp_hit, a[k-3][0]);
            chk("R5", "snp_perr", snp_perr, bp[k-3]);
            chk("R9", "upd_valid", upd_valid, a[k-3][0]);
            if (a[k-3][0]) begin
               chk("R9", "upd_addr", upd_addr, a[k-3]);
               chk("R6", "upd_state", upd_state, iv[k-3] ? 2'b00 : 2'b01);
            end
         end
         if (k < 4) drive(1'b1, a[k], iv[k], bp[k]);
         else       drive(1'b0, '0, 1'b0, 1'b0);
      end
   endtask

   task automatic t_conflict;
      logic [AW-1:0] m, c;
      m = 27'h1234563;   // modified
      c = 27'h0BEEF01;   // clean hit
      @(negedge clk); drive(1'b1, m, 1'b0, 1'b0);
      @(negedge clk); drive(1'b0, '0, 1'b0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      chk("R7", "snp_hitm", snp_hitm, 1);
      @(negedge clk); drive(1'b1, c, 1'b1, 1'b0);
      @(negedge clk); drive(1'b0, '0, 1'b0, 1'b0); wb_done = 1'b1;
      @(negedge clk); wb_done = 1'b0;
      chk("R7", "snp_hitm dropped", snp_hitm, 0);
      @(negedge clk);
      chk("R10", "first upd_valid", upd_valid, 1);
      chk("R10", "first upd_addr clean", upd_addr, c);
      chk("R10", "first upd_state", upd_state, 2'b00);
      @(negedge clk);
      chk("R10", "second upd_valid", upd_valid, 1);
      chk("R10", "second upd_addr wb", upd_addr, m);
      chk("R8", "second upd_state shared", upd_state, 2'b01);
      @(negedge clk);
      chk("R10", "no third update", upd_valid, 0);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000 && !done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single(27'h0ABCDE1, 1'b0, 1'b0);   // hit, shared
      t_single(27'h0ABCDE0, 1'b0, 1'b0);   // miss
      t_single(27'h3000005, 1'b1, 1'b0);   // hit, invalid
      t_single(27'h3000004, 1'b1, 1'b1);   // miss, bad parity
      t_single(27'h5555551, 1'b0, 1'b1);   // hit, bad parity
      t_modified(27'h2222223, 1'b1);
      t_modified(27'h4444447, 1'b0);
      t_back_to_back();
      t_conflict();
      repeat (3) @(negedge clk);
      chk("R4", "snp_hit idle hold", snp_hit, 1);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule